// File: doc/BRIEF.md
# Speculative Retirement Queue

This block holds in-flight instructions of an out-of-order core in program order and retires them one at a time. An instruction that issues claims the next free slot and receives that slot's index as its destination tag. Results broadcast on the shared result bus later fill the slot with that tag and mark it complete. Results may arrive in any order, but only the oldest slot may retire, and only once it is complete.

There are three ways to retire. A register-producing instruction writes its value to the register file. A store writes memory, and only at retirement, never when its data arrives on the bus. A branch writes nothing. If the bus marked the branch as mispredicted, retiring it raises a flush pulse, discards every younger slot and restarts both pointers at the slot just after the branch.

The slots form a ring of `DEPTH` entries, where `DEPTH` is a power of two. The head and tail pointers each carry one extra wrap bit, so the queue can tell full from empty.

Top module: `reorder_queue`

## Requirements
- R1: After reset the queue is empty: `al_ready` is 1, `al_tag` is 0, and `cm_reg_we`, `cm_mem_we` and `flush_o` are all 0.
- R2: An allocation takes place at a clock edge when `al_valid` and `al_ready` are both 1. It takes the slot whose index is on `al_tag`, and successive allocations receive consecutive tags modulo `DEPTH`.
- R3: When `DEPTH` slots are occupied, `al_ready` is 0. This holds even in a cycle where the oldest slot retires, so an allocation is refused in that cycle.
- R4: A bus write (`cdb_valid`=1) whose tag names an occupied slot stores `cdb_value` and `cdb_mispred` in that slot and marks it complete. A bus write naming an unoccupied slot has no effect, so a later allocation of that slot starts incomplete.
- R5: Retirement happens only for the oldest slot, only when that slot is complete, and for at most one slot per cycle. The retire outputs reflect the oldest slot combinationally in the cycle before the edge that removes it.
- R6: Kind code 0 (register) retires with `cm_reg_we`=1, `cm_reg_idx` equal to the allocated destination and `cm_data` equal to the captured value.
- R7: Kind code 1 (store) retires with `cm_mem_we`=1, `cm_mem_addr` equal to the allocated destination and `cm_data` equal to the captured value. The memory write never occurs before the store is the oldest slot.
- R8: Kind codes 2 and 3 (branch) with no mispredict flag retire with no register write, no memory write and no flush.
- R9: A branch retiring with the mispredict flag drives `flush_o`=1 for that cycle and forces `al_ready` to 0 in that cycle. It empties the queue and moves both pointers to the slot after the branch, so the next allocation tag is the branch tag plus one modulo `DEPTH`.
- R10: Slots retire in allocation order regardless of the order in which their results arrive.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| al_valid | input | 1 | Allocation request |
| al_kind | input | 2 | 0 register, 1 store, 2 or 3 branch |
| al_dest | input | DEST_W | Destination register index or store address |
| al_ready | output | 1 | A slot can be allocated this cycle |
| al_tag | output | TAG_W | Tag given to an allocation this cycle |
| cdb_valid | input | 1 | Result bus write |
| cdb_tag | input | TAG_W | Slot the result belongs to |
| cdb_value | input | DATA_W | Result value or store data |
| cdb_mispred | input | 1 | Branch outcome disagreed with prediction |
| cm_reg_we | output | 1 | Register file write at retirement |
| cm_reg_idx | output | DEST_W | Register written |
| cm_mem_we | output | 1 | Memory write at retirement |
| cm_mem_addr | output | DEST_W | Memory address written |
| cm_data | output | DATA_W | Data for either write |
| flush_o | output | 1 | Mispredicted branch retired; younger work discarded |

## Verification
Three events can fall in the same cycle: retirement of the oldest slot, an allocation, and a result-bus write.

The sharpest case is a full queue whose oldest slot retires while `al_valid` is held high. A directed phase fills the queue with no results and then completes only the head. The bench expects `al_ready` to stay 0 in the retiring cycle and the queue to hold `DEPTH`-1 entries afterwards.

Constrained random traffic also places allocations and bus writes, including writes to free slots, inside flush cycles. Each cycle, a bench model of the queue predicts every output, and each output is compared against that prediction.

// File: rtl/reorder_pkg.sv
package reorder_pkg;
  localparam logic [1:0] KIND_REG   = 2'd0;
  localparam logic [1:0] KIND_STORE = 2'd1;

  function automatic logic kind_is_branch(input logic [1:0] k);
    return k[1];
  endfunction
endpackage

// File: rtl/rq_ptr_ctrl.sv
module rq_ptr_ctrl #(
  parameter int DEPTH = 8,
  localparam int TAG_W = $clog2(DEPTH),
  localparam int PTR_W = TAG_W + 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             push,
  input  logic             pop,
  input  logic             flush,
  output logic [PTR_W-1:0] head_q,
  output logic [PTR_W-1:0] tail_q,
  output logic [PTR_W-1:0] occ,
  output logic             full
);
  function automatic logic [PTR_W-1:0] bump(input logic [PTR_W-1:0] p);
    return p + {{(PTR_W-1){1'b0}}, 1'b1};
  endfunction

  assign occ  = tail_q - head_q;
  assign full = (occ == PTR_W'(DEPTH));

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      head_q <= '0;
      tail_q <= '0;
    end else if (flush) begin
      head_q <= bump(head_q);
      tail_q <= bump(head_q);
    end else begin
      if (pop)  head_q <= bump(head_q);
      if (push) tail_q <= bump(tail_q);
    end
  end
endmodule

// File: rtl/rq_slot_array.sv
module rq_slot_array #(
  parameter int DEPTH  = 8,
  parameter int DEST_W = 16,
  parameter int DATA_W = 32,
  localparam int TAG_W = $clog2(DEPTH)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wipe,
  input  logic              alloc_en,
  input  logic [TAG_W-1:0]  alloc_idx,
  input  logic [1:0]        alloc_kind,
  input  logic [DEST_W-1:0] alloc_dest,
  input  logic              res_en,
  input  logic [TAG_W-1:0]  res_idx,
  input  logic [DATA_W-1:0] res_value,
  input  logic              res_mis,
  input  logic              drop_en,
  input  logic [TAG_W-1:0]  rd_idx,
  output logic              rd_busy,
  output logic              rd_done,
  output logic [1:0]        rd_kind,
  output logic [DEST_W-1:0] rd_dest,
  output logic [DATA_W-1:0] rd_value,
  output logic              rd_mis
);
  logic [DEPTH-1:0] busy_q, done_q, mis_q;
  logic [1:0]        kind_q  [DEPTH];
  logic [DEST_W-1:0] dest_q  [DEPTH];
  logic [DATA_W-1:0] value_q [DEPTH];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      busy_q <= '0;
      done_q <= '0;
      mis_q  <= '0;
      for (int i = 0; i < DEPTH; i++) begin
        kind_q[i]  <= '0;
        dest_q[i]  <= '0;
        value_q[i] <= '0;
      end
    end else if (wipe) begin
      busy_q <= '0;
      done_q <= '0;
    end else begin
      for (int i = 0; i < DEPTH; i++) begin
        if (alloc_en && alloc_idx == TAG_W'(i)) begin
          busy_q[i] <= 1'b1;
          done_q[i] <= 1'b0;
          mis_q[i]  <= 1'b0;
          kind_q[i] <= alloc_kind;
          dest_q[i] <= alloc_dest;
        end else begin
          if (drop_en && rd_idx == TAG_W'(i)) busy_q[i] <= 1'b0;
          if (res_en && res_idx == TAG_W'(i) && busy_q[i]) begin
            done_q[i]  <= 1'b1;
            value_q[i] <= res_value;
            mis_q[i]   <= res_mis;
          end
        end
      end
    end
  end

  assign rd_busy  = busy_q[rd_idx];
  assign rd_done  = done_q[rd_idx];
  assign rd_kind  = kind_q[rd_idx];
  assign rd_dest  = dest_q[rd_idx];
  assign rd_value = value_q[rd_idx];
  assign rd_mis   = mis_q[rd_idx];
endmodule

// File: rtl/rq_retire_sel.sv
module rq_retire_sel
  import reorder_pkg::*;
#(
  parameter int DEST_W = 16,
  parameter int DATA_W = 32
) (
  input  logic              hd_busy,
  input  logic              hd_done,
  input  logic [1:0]        hd_kind,
  input  logic [DEST_W-1:0] hd_dest,
  input  logic [DATA_W-1:0] hd_value,
  input  logic              hd_mis,
  output logic              retire,
  output logic              reg_we,
  output logic              mem_we,
  output logic              squash,
  output logic [DEST_W-1:0] dest,
  output logic [DATA_W-1:0] data
);
  always_comb begin
    retire = hd_busy && hd_done;
    reg_we = retire && (hd_kind == KIND_REG);
    mem_we = retire && (hd_kind == KIND_STORE);
    squash = retire && kind_is_branch(hd_kind) && hd_mis;
    dest   = hd_dest;
    data   = hd_value;
  end
endmodule

// File: rtl/reorder_queue.sv
module reorder_queue #(
  parameter int DEPTH  = 8,
  parameter int DEST_W = 16,
  parameter int DATA_W = 32,
  localparam int TAG_W = $clog2(DEPTH),
  localparam int PTR_W = TAG_W + 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              al_valid,
  input  logic [1:0]        al_kind,
  input  logic [DEST_W-1:0] al_dest,
  output logic              al_ready,
  output logic [TAG_W-1:0]  al_tag,
  input  logic              cdb_valid,
  input  logic [TAG_W-1:0]  cdb_tag,
  input  logic [DATA_W-1:0] cdb_value,
  input  logic              cdb_mispred,
  output logic              cm_reg_we,
  output logic [DEST_W-1:0] cm_reg_idx,
  output logic              cm_mem_we,
  output logic [DEST_W-1:0] cm_mem_addr,
  output logic [DATA_W-1:0] cm_data,
  output logic              flush_o
);
  logic [PTR_W-1:0]  head_q, tail_q, occ;
  logic              full;
  logic              do_alloc, do_retire, do_flush;
  logic              hd_busy, hd_done, hd_mis;
  logic [1:0]        hd_kind;
  logic [DEST_W-1:0] hd_dest, ret_dest;
  logic [DATA_W-1:0] hd_value;

  assign al_ready = !full && !do_flush;
  assign do_alloc = al_valid && al_ready;
  assign al_tag   = tail_q[TAG_W-1:0];

  rq_ptr_ctrl #(.DEPTH(DEPTH)) u_ptr (
    .clk(clk), .rst_n(rst_n), .push(do_alloc), .pop(do_retire),
    .flush(do_flush), .head_q(head_q), .tail_q(tail_q), .occ(occ), .full(full)
  );

  rq_slot_array #(.DEPTH(DEPTH), .DEST_W(DEST_W), .DATA_W(DATA_W)) u_slots (
    .clk(clk), .rst_n(rst_n), .wipe(do_flush),
    .alloc_en(do_alloc), .alloc_idx(al_tag), .alloc_kind(al_kind), .alloc_dest(al_dest),
    .res_en(cdb_valid), .res_idx(cdb_tag), .res_value(cdb_value), .res_mis(cdb_mispred),
    .drop_en(do_retire), .rd_idx(head_q[TAG_W-1:0]),
    .rd_busy(hd_busy), .rd_done(hd_done), .rd_kind(hd_kind),
    .rd_dest(hd_dest), .rd_value(hd_value), .rd_mis(hd_mis)
  );

  rq_retire_sel #(.DEST_W(DEST_W), .DATA_W(DATA_W)) u_sel (
    .hd_busy(hd_busy), .hd_done(hd_done), .hd_kind(hd_kind), .hd_dest(hd_dest),
    .hd_value(hd_value), .hd_mis(hd_mis),
    .retire(do_retire), .reg_we(cm_reg_we), .mem_we(cm_mem_we), .squash(do_flush),
    .dest(ret_dest), .data(cm_data)
  );

  assign cm_reg_idx  = ret_dest;
  assign cm_mem_addr = ret_dest;
  assign flush_o     = do_flush;
endmodule

// File: rtl/reorder_queue_chk.sv
module reorder_queue_chk #(
  parameter int DEPTH = 8,
  localparam int PTR_W = $clog2(DEPTH) + 1
) (
  input logic             clk,
  input logic             rst_n,
  input logic             al_ready,
  input logic             do_alloc,
  input logic             do_retire,
  input logic             cm_reg_we,
  input logic             cm_mem_we,
  input logic             flush_o,
  input logic             hd_busy,
  input logic [PTR_W-1:0] occ
);
  // R3
  full_refuse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    occ == PTR_W'(DEPTH) |-> !al_ready);

  // R5
  single_retire_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({cm_reg_we, cm_mem_we, flush_o}));

  // R5
  retire_needs_entry_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cm_reg_we || cm_mem_we || flush_o) |-> hd_busy && occ != '0);

  // R9
  flush_empties_chk: assert property (@(posedge clk) disable iff (!rst_n)
    flush_o |=> occ == '0);

  // R9
  flush_blocks_alloc_chk: assert property (@(posedge clk) disable iff (!rst_n)
    flush_o |-> !do_alloc);

  // R2
  occupancy_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(rst_n) && !$past(flush_o)) |->
      occ == $past(occ) + PTR_W'($past(do_alloc)) - PTR_W'($past(do_retire)));
endmodule

bind reorder_queue reorder_queue_chk #(.DEPTH(DEPTH)) u_chk (
  .clk(clk), .rst_n(rst_n), .al_ready(al_ready), .do_alloc(do_alloc),
  .do_retire(do_retire), .cm_reg_we(cm_reg_we), .cm_mem_we(cm_mem_we),
  .flush_o(flush_o), .hd_busy(hd_busy), .occ(occ)
);

// File: tb/reorder_queue_test.sv
module reorder_queue_test;
  localparam int CLK_PERIOD = 10;
  localparam int D = 8;
  localparam int DW = 16;
  localparam int VW = 32;
  localparam int TW = $clog2(D);

  logic clk = 0, rst_n = 0;
  logic al_valid = 0; logic [1:0] al_kind = 0; logic [DW-1:0] al_dest = 0;
  logic al_ready; logic [TW-1:0] al_tag;
  logic cdb_valid = 0; logic [TW-1:0] cdb_tag = 0; logic [VW-1:0] cdb_value = 0;
  logic cdb_mispred = 0;
  logic cm_reg_we, cm_mem_we, flush_o;
  logic [DW-1:0] cm_reg_idx, cm_mem_addr; logic [VW-1:0] cm_data;

  int checks = 0, fails = 0;
  bit done = 0;

  int m_head = 0, m_tail = 0, m_cnt = 0;
  bit m_busy[D], m_rdy[D], m_mis[D];
  int m_kind[D]; logic [DW-1:0] m_dest[D]; logic [VW-1:0] m_val[D];

  reorder_queue #(.DEPTH(D), .DEST_W(DW), .DATA_W(VW)) uut (.*);

  always #(CLK_PERIOD/2) clk = ~clk;

  task automatic chk(input string req, input string what, input longint act, input longint exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  function automatic bit exp_retire();  return m_busy[m_head] && m_rdy[m_head]; endfunction
  function automatic bit exp_reg();     return exp_retire() && m_kind[m_head] == 0; endfunction
  function automatic bit exp_mem();     return exp_retire() && m_kind[m_head] == 1; endfunction
  function automatic bit exp_flush();   return exp_retire() && m_kind[m_head] >= 2 && m_mis[m_head]; endfunction
  function automatic bit exp_ready();   return m_cnt < D && !exp_flush(); endfunction

  task automatic compare_outputs();
    string br;
    br = (exp_retire() && m_kind[m_head] >= 2) ? "R8 R9" : "R5";
    chk(m_cnt == D ? "R3" : "R9", "al_ready", al_ready, exp_ready());
    chk("R2", "al_tag", al_tag, m_tail);
    chk("R6 R10", "cm_reg_we", cm_reg_we, exp_reg());
    chk("R7", "cm_mem_we", cm_mem_we, exp_mem());
    chk(br, "flush_o", flush_o, exp_flush());
    if (exp_reg()) begin
      chk("R6", "cm_reg_idx", cm_reg_idx, m_dest[m_head]);
      chk("R4 R10", "cm_data", cm_data, m_val[m_head]);
    end
    if (exp_mem()) begin
      chk("R7", "cm_mem_addr", cm_mem_addr, m_dest[m_head]);
      chk("R4 R7", "cm_data", cm_data, m_val[m_head]);
    end
  endtask

  // advance the model across the coming edge with the inputs now driven
  task automatic model_step();
    bit ret, fl, alo;
    ret = exp_retire(); fl = exp_flush(); alo = al_valid && exp_ready();
    if (fl) begin
      for (int i = 0; i < D; i++) m_busy[i] = 0;
      m_head = (m_head + 1) % D; m_tail = m_head; m_cnt = 0;
    end else begin
      if (cdb_valid && m_busy[cdb_tag]) begin
        m_rdy[cdb_tag] = 1; m_val[cdb_tag] = cdb_value; m_mis[cdb_tag] = cdb_mispred;
      end
      if (alo) begin
        m_busy[m_tail] = 1; m_rdy[m_tail] = 0; m_mis[m_tail] = 0;
        m_kind[m_tail] = al_kind; m_dest[m_tail] = al_dest;
        m_tail = (m_tail + 1) % D; m_cnt++;
      end
      if (ret) begin
        m_busy[m_head] = 0; m_head = (m_head + 1) % D; m_cnt--;
      end
    end
  endtask

  task automatic cycle();
    compare_outputs();
    model_step();
    @(negedge clk);
  endtask

  task automatic pick_cdb(input bit any_tag);
    int cand[$];
    for (int i = 0; i < D; i++) if (m_busy[i] && !m_rdy[i]) cand.push_back(i);
    cdb_value = $urandom; cdb_mispred = ($urandom % 3) == 0;
    if (any_tag) begin
      cdb_valid = 1; cdb_tag = TW'($urandom % D);
    end else if (cand.size() > 0) begin
      cdb_valid = 1; cdb_tag = TW'(cand[$urandom % cand.size()]);
    end else cdb_valid = 0;
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    fails++;
    $display("FAIL watchdog actual=running expected=finished");
    if (!done) begin
      $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'h5eed_0042));
    repeat (3) @(negedge clk);
    rst_n = 1;
    // R1 reset state
    chk("R1", "al_ready", al_ready, 1);
    chk("R1", "al_tag", al_tag, 0);
    chk("R1", "cm_reg_we", cm_reg_we, 0);
    chk("R1", "cm_mem_we", cm_mem_we, 0);
    chk("R1", "flush_o", flush_o, 0);

    // R4 write to a free slot is ignored; slot later allocated stays incomplete
    cdb_valid = 1; cdb_tag = 0; cdb_value = 32'hdead; cdb_mispred = 0;
    cycle();
    cdb_valid = 0;

    // R3 fill to full with no results, then complete only the head while pushing
    for (int i = 0; i < D + 2; i++) begin
      al_valid = 1; al_kind = 0; al_dest = DW'(i + 1);
      cycle();
    end
    chk("R3", "al_ready full", al_ready, 0);
    cdb_valid = 1; cdb_tag = TW'(m_head); cdb_value = 32'h1234_5678; cdb_mispred = 0;
    cycle();
    cdb_valid = 0;
    cycle();   // head retires here while full and al_valid high
    cycle();
    al_valid = 0;

    // R10 complete remaining entries youngest-first
    for (int i = D - 1; i >= 0; i--) begin
      if (m_busy[(m_head + i) % D] && !m_rdy[(m_head + i) % D]) begin
        cdb_valid = 1; cdb_tag = TW'((m_head + i) % D); cdb_value = $urandom; cdb_mispred = 0;
        cycle();
      end
    end
    cdb_valid = 0;
    repeat (D + 2) cycle();

    // R9 directed mispredicted branch behind a store
    al_valid = 1; al_kind = 1; al_dest = 16'h0abc; cycle();
    al_kind = 2; al_dest = 0; cycle();
    al_kind = 0; al_dest = 3; cycle();
    al_valid = 0;
    cdb_valid = 1; cdb_tag = TW'((m_tail + D - 2) % D); cdb_value = 0; cdb_mispred = 1; cycle();
    cdb_tag = TW'((m_tail + D - 1) % D); cdb_value = 32'h77; cdb_mispred = 0; cycle();
    cdb_tag = TW'((m_tail + D - 3) % D); cdb_value = 32'h55; cycle();
    cdb_valid = 0;
    repeat (4) cycle();

    // constrained random traffic
    for (int n = 0; n < 4000; n++) begin
      al_valid = ($urandom % 4) != 0;
      al_kind = 2'($urandom % 4);
      al_dest = DW'($urandom);
      if (($urandom % 3) != 0) pick_cdb(($urandom % 8) == 0);
      else cdb_valid = 0;
      cycle();
    end
    al_valid = 0; cdb_valid = 0;
    cycle();

    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end
endmodule